// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit timer-counter with a companion 16-bit register that acts as either a capture target or a reload source. Software programs it through a small write port. A control word selects the run state, the count source, capture or reload behaviour, the external trigger enable, the down-count enable and a baud-clock mode. Two flags, overflow and external, are sticky and drive one interrupt request.

In timer function the count advances once per machine cycle, which is `DIV` clocks (12 by default). In counter function it advances on falling edges of the count pin. That pin is sampled once per machine cycle, so the fastest count rate is one per two machine cycles.

A second pin, the trigger pin, is sampled the same way. Depending on the mode, it captures the running count, forces a reload, or sets the count direction. In the up/down reload mode, underflow is detected when the count equals the reload value. In that mode the external flag toggles on every wrap, acting as a seventeenth count bit, and it does not raise the interrupt.

Top module: `cr_timer16`

## Requirements
- R1: After reset the count, the reload/capture register, both flags and `irq_o` are 0, and `mode_o` reads 0 (off).
- R2: `mode_o` encodes the mode as follows: 0 = off (run bit 0), 3 = baud (run 1, baud bit 1), 2 = capture (run 1, baud 0, capture bit 1), 1 = reload (run 1, baud 0, capture 0). In modes 0 and 3 the count holds its value.
- R3: In timer function (count-select bit 0) the count rises by exactly one every `DIV` clocks.
- R4: In counter function (count-select bit 1) the count rises by one for each machine-cycle sample pair of high then low on `cnt_pin`. It does not change while the pin is static.
- R5: In capture mode a step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: In capture mode with the trigger-enable bit set, a falling edge on `trig_pin` copies the count into the reload/capture register and sets the external flag. With the bit clear, the edge changes nothing.
- R7: In reload mode with down-enable 0, a step from 0xFFFF loads the reload value and sets the overflow flag.
- R8: In reload mode with down-enable 0 and trigger-enable 1, a falling edge on `trig_pin` loads the reload value and sets the external flag.
- R9: In reload mode with down-enable 1 and `trig_pin` low, the count falls by one per step. A step taken while the count equals the reload value loads 0xFFFF, sets the overflow flag and inverts the external flag.
- R10: In reload mode with down-enable 1 and `trig_pin` high, the count rises. A step from 0xFFFF loads the reload value, sets the overflow flag and inverts the external flag.
- R11: Both flags stay set until a control write. One clock after a flag change, `irq_o` equals overflow OR external, except in reload mode with down-enable 1, where only overflow counts.
- R12: Write address 0 is control, with fields run[0], count-select[1], capture[2], trigger-enable[3], down-enable[4], baud[5], overflow[6] and external[7]. Address 1 is the count and address 2 is the reload/capture register. A write takes priority over a hardware update in the same cycle, and address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W | Write data |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Capture/reload trigger or direction input |
| count_o | output | W | Current count |
| reload_o | output | W | Reload/capture register |
| ovf_o | output | 1 | Overflow/underflow flag |
| ext_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| mode_o | output | 2 | Decoded mode |

## Verification
The bench puts the count one or two steps below the wrap point and checks the exact landing value after the wrap. A design that reloads one step late, or that wraps to zero in reload mode, shows a wrong landing value.

Down-counting starts two above the reload value and must land on 0xFFFF. Comparing against zero instead, or being off by one in the comparison, gives a different result. In up/down mode the external flag is preset to 1, so the bench can tell a toggle from a plain set. The bench also checks that this flag does not reach the interrupt.

Capture and reload triggers are applied while the count is frozen, so the copied value is exact. The bench also checks that a trigger with the enable bit clear leaves the register alone. Finally, it checks that a static count pin never counts, that the off and baud modes freeze the count, and that the unused write address changes nothing.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_BAUD    = 2'd3
  } crt_mode_e;

  // Packed so that run sits in bit 0 and baud in bit 5 of the control word.
  typedef struct packed {
    logic baud;
    logic down_en;
    logic ext_en;
    logic capture;
    logic cnt_sel;
    logic run;
  } crt_ctl_t;

  localparam int CTL_BITS = 6;
  localparam int FLAG_OVF_BIT = 6;
  localparam int FLAG_EXT_BIT = 7;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_RLD = 2'd2;

  function automatic crt_mode_e decode_mode(input crt_ctl_t c);
    if (!c.run)          return MODE_OFF;
    else if (c.baud)     return MODE_BAUD;
    else if (c.capture)  return MODE_CAPTURE;
    else                 return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/crt_tick_gen.sv
module crt_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/crt_edge_det.sv
module crt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic pin,
  output logic level_o,
  output logic fall_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      // Previous sample high, new sample low: a one-clock pulse.
      fall_o <= sample_en & level_o & ~pin;
      if (sample_en) level_o <= pin;
    end
  end
endmodule

// File: rtl/crt_core.sv
module crt_core
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  input  logic         trig_fall,
  input  logic         trig_level,
  output crt_ctl_t     ctl_o,
  output crt_mode_e    mode_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         ovf_o,
  output logic         ext_o,
  output logic         irq_o
);
  localparam logic [W-1:0] TOP = '1;

  crt_ctl_t     ctl_q;
  logic [W-1:0] cnt_q, rld_q;
  logic         ovf_q, ext_q, irq_q;
  crt_mode_e    mode;

  assign mode = decode_mode(ctl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf_q | (ext_q & ~((mode == MODE_RELOAD) & ctl_q.down_en));
      case (mode)
        MODE_CAPTURE: begin
          if (step) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TOP) ovf_q <= 1'b1;
          end
          if (ctl_q.ext_en && trig_fall) begin
            rld_q <= cnt_q;
            ext_q <= 1'b1;
          end
        end
        MODE_RELOAD: begin
          if (ctl_q.down_en) begin
            if (step) begin
              if (trig_level) begin
                if (cnt_q == TOP) begin
                  cnt_q <= rld_q;
                  ovf_q <= 1'b1;
                  ext_q <= ~ext_q;
                end else begin
                  cnt_q <= cnt_q + 1'b1;
                end
              end else if (cnt_q == rld_q) begin
                cnt_q <= TOP;
                ovf_q <= 1'b1;
                ext_q <= ~ext_q;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end else begin
            if (step) begin
              if (cnt_q == TOP) begin
                cnt_q <= rld_q;
                ovf_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            if (ctl_q.ext_en && trig_fall) begin
              cnt_q <= rld_q;
              ext_q <= 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (wr_en) begin
        case (wr_addr)
          ADDR_CTL: begin
            ctl_q <= crt_ctl_t'(wr_data[CTL_BITS-1:0]);
            ovf_q <= wr_data[FLAG_OVF_BIT];
            ext_q <= wr_data[FLAG_EXT_BIT];
          end
          ADDR_CNT: cnt_q <= wr_data;
          ADDR_RLD: rld_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign ctl_o    = ctl_q;
  assign mode_o   = mode;
  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign ovf_o    = ovf_q;
  assign ext_o    = ext_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import crt_pkg::*;
#(
  parameter int W   = 16,
  parameter int DIV = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         cnt_pin,
  input  logic         trig_pin,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         ovf_o,
  output logic         ext_o,
  output logic         irq_o,
  output logic [1:0]   mode_o
);
  logic      tick, cnt_fall, cnt_level, trig_fall, trig_level, step;
  crt_ctl_t  ctl;
  crt_mode_e mode;

  crt_tick_gen #(.DIV(DIV)) tick_i (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  crt_edge_det cnt_det_i (
    .clk(clk), .rst(rst), .sample_en(tick), .pin(cnt_pin),
    .level_o(cnt_level), .fall_o(cnt_fall)
  );

  crt_edge_det trig_det_i (
    .clk(clk), .rst(rst), .sample_en(tick), .pin(trig_pin),
    .level_o(trig_level), .fall_o(trig_fall)
  );

  assign step = ctl.cnt_sel ? cnt_fall : tick;

  crt_core #(.W(W)) core_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .step(step), .trig_fall(trig_fall), .trig_level(trig_level),
    .ctl_o(ctl), .mode_o(mode), .count_o(count_o), .reload_o(reload_o),
    .ovf_o(ovf_o), .ext_o(ext_o), .irq_o(irq_o)
  );

  assign mode_o = mode;

  logic unused_level;
  assign unused_level = cnt_level;
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         step,
  input logic         trig_fall,
  input logic         trig_level,
  input crt_ctl_t     ctl,
  input logic [1:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] reload,
  input logic         ovf,
  input logic         ext,
  input logic         irq
);
  localparam logic [W-1:0] TOP = '1;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && reload == '0 && !ovf && !ext && !irq && mode == 2'd0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_OFF || mode == MODE_BAUD) && !wr_en) |=> $stable(count));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE && step && count == TOP && !wr_en) |=> (count == '0 && ovf));

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE && ctl.ext_en && trig_fall && !wr_en)
      |=> (reload == $past(count) && ext));

  assert_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RELOAD && ctl.down_en && step && !trig_level && count == reload && !wr_en)
      |=> (count == TOP && ovf && ext != $past(ext)));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_en) |=> ovf);

  assert_irq_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(ovf | (ext & !(mode == MODE_RELOAD && ctl.down_en)))));
endmodule

bind cr_timer16 cr_timer16_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .step(step), .trig_fall(trig_fall),
  .trig_level(trig_level), .ctl(ctl), .mode(mode_o), .count(count_o),
  .reload(reload_o), .ovf(ovf_o), .ext(ext_o), .irq(irq_o)
);

// File: tb/cr_timer16_tb.sv
module cr_timer16_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DIV = 12;

  localparam logic [15:0] C_RUN = 16'h01, C_CNT = 16'h02, C_CAP = 16'h04,
                          C_EXT = 16'h08, C_DN  = 16'h10, C_BAUD = 16'h20,
                          C_FEXT = 16'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic cnt_pin = 1'b1, trig_pin = 1'b1;
  logic [W-1:0] count_o, reload_o;
  logic ovf_o, ext_o, irq_o;
  logic [1:0] mode_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_timer16 #(.W(W), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .count_o(count_o), .reload_o(reload_o),
    .ovf_o(ovf_o), .ext_o(ext_o), .irq_o(irq_o), .mode_o(mode_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b0; wait_clk(4*DIV);
    trig_pin = 1'b1; wait_clk(4*DIV);
  endtask

  task automatic t_reset();
    check(count_o, 0, "R1 count");
    check(reload_o, 0, "R1 reload");
    check({ovf_o, ext_o, irq_o}, 0, "R1 flags");
    check(mode_o, 0, "R1 mode");
  endtask

  task automatic t_timer();
    logic [15:0] c0;
    wr(1, 16'h0010);
    wr(0, C_RUN | C_CAP);
    check(mode_o, 2, "R2 capture mode code");
    c0 = count_o;
    wait_clk(10*DIV);
    check(count_o - c0, 10, "R3 ten steps in 10*DIV clocks");
  endtask

  task automatic t_cap_wrap();
    wr(0, 0);
    wr(1, 16'hFFFE);
    wr(0, C_RUN | C_CAP);
    wait_clk(3*DIV);
    check(count_o, 16'h0001, "R5 wrap to zero");
    check(ovf_o, 1, "R5 overflow flag");
    wait_clk(2);
    check(irq_o, 1, "R11 irq from overflow");
    wait_clk(DIV);
    check(ovf_o, 1, "R11 overflow sticky");
    wr(0, C_RUN | C_CAP);
    check(ovf_o, 0, "R11 cleared by control write");
    wait_clk(2);
    check(irq_o, 0, "R11 irq drops");
  endtask

  task automatic t_counter();
    wr(0, 0);
    cnt_pin = 1'b1; wait_clk(4*DIV);
    wr(1, 16'h0100);
    wr(0, C_RUN | C_CAP | C_CNT);
    wait_clk(4*DIV);
    check(count_o, 16'h0100, "R4 static high no count");
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; wait_clk(4*DIV);
      cnt_pin = 1'b1; wait_clk(4*DIV);
    end
    check(count_o, 16'h0105, "R4 five falling edges");
    cnt_pin = 1'b0; wait_clk(20*DIV);
    check(count_o, 16'h0106, "R4 one edge then static low");
    cnt_pin = 1'b1; wait_clk(4*DIV);
  endtask

  task automatic t_capture();
    wr(0, 0);
    cnt_pin = 1'b1; trig_pin = 1'b1; wait_clk(4*DIV);
    wr(2, 16'h0000);
    wr(1, 16'h5A5A);
    wr(0, C_RUN | C_CAP | C_CNT | C_EXT);
    trig_pulse();
    check(reload_o, 16'h5A5A, "R6 captured value");
    check(ext_o, 1, "R6 external flag");
    check(count_o, 16'h5A5A, "R6 count untouched");
    check(irq_o, 1, "R11 irq from external flag");
    wr(2, 16'h1111);
    wr(0, C_RUN | C_CAP | C_CNT);
    trig_pulse();
    check(reload_o, 16'h1111, "R6 disabled trigger ignored");
    check(ext_o, 0, "R6 no flag when disabled");
  endtask

  task automatic t_reload_up();
    wr(0, 0);
    wr(2, 16'h1234);
    wr(1, 16'hFFFE);
    wr(0, C_RUN);
    check(mode_o, 1, "R2 reload mode code");
    wait_clk(3*DIV);
    check(count_o, 16'h1235, "R7 reload on overflow");
    check(ovf_o, 1, "R7 overflow flag");
  endtask

  task automatic t_trig_reload();
    wr(0, 0);
    cnt_pin = 1'b1; trig_pin = 1'b1; wait_clk(4*DIV);
    wr(2, 16'hABCD);
    wr(1, 16'h0100);
    wr(0, C_RUN | C_CNT | C_EXT);
    trig_pulse();
    check(count_o, 16'hABCD, "R8 trigger reload");
    check(ext_o, 1, "R8 external flag");
    check(ovf_o, 0, "R8 no overflow");
  endtask

  task automatic t_down();
    wr(0, 0);
    trig_pin = 1'b0; wait_clk(4*DIV);
    wr(2, 16'h1000);
    wr(1, 16'h1002);
    wr(0, C_RUN | C_DN);
    wait_clk(3*DIV);
    check(count_o, 16'hFFFF, "R9 underflow at reload value");
    check(ovf_o, 1, "R9 overflow flag");
    check(ext_o, 1, "R9 external toggled");
    wr(0, C_RUN | C_DN | C_FEXT);
    wait_clk(3);
    check(ext_o, 1, "R11 external flag held");
    check(irq_o, 0, "R11 external flag masked in up/down mode");
  endtask

  task automatic t_updown_up();
    wr(0, 0);
    trig_pin = 1'b1; wait_clk(4*DIV);
    wr(2, 16'h2000);
    wr(1, 16'hFFFE);
    wr(0, C_RUN | C_DN | C_FEXT);
    wait_clk(3*DIV);
    check(count_o, 16'h2001, "R10 up wrap reload");
    check(ovf_o, 1, "R10 overflow flag");
    check(ext_o, 0, "R10 external toggled 1->0");
  endtask

  task automatic t_hold();
    wr(0, 0);
    wr(1, 16'h4321);
    wr(0, C_RUN | C_BAUD);
    check(mode_o, 3, "R2 baud mode code");
    wait_clk(5*DIV);
    check(count_o, 16'h4321, "R2 baud holds count");
    wr(0, 0);
    check(mode_o, 0, "R2 off mode code");
    wait_clk(5*DIV);
    check(count_o, 16'h4321, "R2 off holds count");
    wr(2, 16'h0F0F);
    wr(3, 16'hFFFF);
    wait_clk(2);
    check(count_o, 16'h4321, "R12 addr 3 count unchanged");
    check(reload_o, 16'h0F0F, "R12 addr 3 reload unchanged");
    check(mode_o, 0, "R12 addr 3 control unchanged");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(1);
    t_reset();
    t_timer();
    t_cap_wrap();
    t_counter();
    t_capture();
    t_reload_up();
    t_trig_reload();
    t_down();
    t_updown_up();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule